// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between a UART's host-side data register, its receive and transmit FIFOs, and the serial line deserializer. A two-bit channel mode picks one of four routings: normal operation, echo (line bytes are received and also sent back out), local loopback (host writes come back as received bytes) and remote loopback (line bytes go straight back out without reaching the host). The FIFO storage lives outside; the router only issues push strobes with data, plus a flush strobe for the transmit FIFO, and reads back both FIFO fill levels.

The line side uses a valid/ready handshake. Ready is the minimum free space over the FIFOs the current mode feeds, with pushes still in flight counted against it, so a byte is only taken when every FIFO it must land in has room. Host data writes into the transmit FIFO are gated by the enable and disable bits of a control register and are dropped with an overrun event when the FIFO is full. Writing the transmit-reset bit produces a single flush pulse; the bit never stays set.

Host access is a single write strobe with a two-bit target select (0 = control, 1 = mode, 2 = data, 3 = no target) and a 10-bit write word.

Top module: `uart_chan_router`

## Requirements
- R1: The channel mode is taken from write-word bits 9:8 of a mode write (other bits have no effect): 0 normal, 1 echo, 2 local loopback, 3 remote loopback. Mode resets to normal.
- R2: In normal mode a host data write pushes write-word bits 7:0 into the transmit FIFO, and an accepted line byte is pushed into the receive FIFO.
- R3: In echo mode an accepted line byte is pushed into the receive FIFO and the transmit FIFO in the same cycle.
- R4: In local loopback a host data write is pushed into the receive FIFO; an accepted line byte is discarded with no push.
- R5: In remote loopback an accepted line byte is pushed into the transmit FIFO only.
- R6: In echo and remote loopback modes a host data write causes no push at all.
- R7: A push into the transmit FIFO happens only while control bit 4 (transmit enable) is 1 and control bit 5 (transmit disable) is 0; after reset the control state is that of value 0x128, so transmit is disabled.
- R8: A host data write aimed at a full FIFO (pending pushes counted) is dropped and pulses bit 5 of the 13-bit event output for one cycle; bit 12 (transmit overrun) is never raised.
- R9: line_ready is 1 when the receive FIFO has room (normal, echo) and the transmit FIFO has room (echo, remote); it is always 1 in local loopback.
- R10: A control write with bit 1 set gives exactly one tx_flush pulse; the bit is not retained, and afterwards the transmit FIFO counts as empty.
- R11: All push, flush and event outputs are registered, appearing in the cycle after the sampling edge, and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 control, 1 mode, 2 data, 3 none |
| host_wdata | input | 10 | Host write word |
| line_valid | input | 1 | Line byte available |
| line_ready | output | 1 | Router can take a line byte this cycle |
| line_data | input | 8 | Line byte |
| rx_level | input | CW | Receive FIFO fill level |
| tx_level | input | CW | Transmit FIFO fill level |
| rx_push | output | 1 | Receive FIFO push strobe |
| rx_push_data | output | 8 | Receive FIFO push byte |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_push_data | output | 8 | Transmit FIFO push byte |
| tx_flush | output | 1 | Transmit FIFO empty strobe |
| evt_set | output | 13 | One-cycle event pulses (bit 5 overrun) |

## Verification
The hardest situation to reach is a full FIFO on the path that the host, not the line, feeds: the line handshake refuses bytes once space runs out, so overruns can only come from host data writes. The stimulus fills the transmit FIFO in remote loopback and the receive FIFO through echo, normal and local loopback traffic, confirms line_ready falls in exactly the modes involving the full FIFO, then switches mode and issues host writes that must be dropped with an event. A transmit reset then empties the transmit side and the stimulus checks that traffic flows again.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  localparam int HW_W      = 10;
  localparam int BYTE_W    = 8;
  localparam int CB_TXRST  = 1;
  localparam int CB_TXEN   = 4;
  localparam int CB_TXDIS  = 5;
  localparam int MODE_LSB  = 8;
  localparam logic [8:0] CTRL_RESET = 9'h128;
  localparam int EVT_W     = 13;
  localparam int EVT_RXOVR = 5;
  localparam int EVT_TXOVR = 12;
endpackage

// File: rtl/ucr_ctrl_regs.sv
module ucr_ctrl_regs
  import ucr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic [1:0] host_sel,
  input  logic       wr_txrst,
  input  logic       wr_txen,
  input  logic       wr_txdis,
  input  logic [1:0] wr_mode,
  output chan_mode_e mode,
  output logic       tx_ok,
  output logic       tx_flush,
  output logic       host_data_wr
);
  logic en_q, dis_q, flush_q;
  chan_mode_e mode_q;
  logic ctrl_wr, mode_wr;

  assign ctrl_wr      = host_wr && (host_sel == SEL_CTRL);
  assign mode_wr      = host_wr && (host_sel == SEL_MODE);
  assign host_data_wr = host_wr && (host_sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= CTRL_RESET[CB_TXEN];
      dis_q   <= CTRL_RESET[CB_TXDIS];
      flush_q <= 1'b0;
      mode_q  <= CH_NORMAL;
    end else begin
      flush_q <= ctrl_wr && wr_txrst;
      if (ctrl_wr) begin
        en_q  <= wr_txen;
        dis_q <= wr_txdis;
      end
      if (mode_wr) mode_q <= chan_mode_e'(wr_mode);
    end
  end

  assign mode     = mode_q;
  assign tx_ok    = en_q && !dis_q;
  assign tx_flush = flush_q;

  // R10: a flush pulse always traces back to a control write carrying the reset bit
  a_r10_flush_source: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> $past(host_wr && host_sel == SEL_CTRL && wr_txrst));
endmodule

// File: rtl/ucr_space.sv
module ucr_space
  import ucr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic [CW-1:0] rx_level,
  input  logic [CW-1:0] tx_level,
  input  logic          rx_pend,
  input  logic          tx_pend,
  input  logic          flush_pend,
  input  chan_mode_e    mode,
  output logic          rx_room,
  output logic          tx_room,
  output logic          line_ready
);
  logic [CW:0] rx_eff, tx_eff;

  always_comb begin
    rx_eff = {1'b0, rx_level} + (CW+1)'(rx_pend);
    if (flush_pend) tx_eff = (CW+1)'(tx_pend);
    else            tx_eff = {1'b0, tx_level} + (CW+1)'(tx_pend);
  end

  assign rx_room = rx_eff < (CW+1)'(DEPTH);
  assign tx_room = tx_eff < (CW+1)'(DEPTH);

  always_comb begin
    unique case (mode)
      CH_NORMAL: line_ready = rx_room;
      CH_ECHO:   line_ready = rx_room && tx_room;
      CH_LOCAL:  line_ready = 1'b1;
      default:   line_ready = tx_room;
    endcase
  end
endmodule

// File: rtl/ucr_steer.sv
module ucr_steer
  import ucr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  chan_mode_e        mode,
  input  logic              tx_ok,
  input  logic              host_data_wr,
  input  logic [BYTE_W-1:0] host_byte,
  input  logic              line_fire,
  input  logic [BYTE_W-1:0] line_byte,
  input  logic              rx_room,
  input  logic              tx_room,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_data,
  output logic              ovr
);
  logic              rx_n, tx_n, ovr_n;
  logic [BYTE_W-1:0] rx_d_n, tx_d_n;

  always_comb begin
    rx_n   = 1'b0;
    tx_n   = 1'b0;
    ovr_n  = 1'b0;
    rx_d_n = line_byte;
    tx_d_n = line_byte;
    unique case (mode)
      CH_NORMAL: begin
        rx_n   = line_fire;
        tx_d_n = host_byte;
        if (host_data_wr && tx_ok) begin
          if (tx_room) tx_n  = 1'b1;
          else         ovr_n = 1'b1;
        end
      end
      CH_ECHO: begin
        rx_n = line_fire;
        tx_n = line_fire && tx_ok;
      end
      CH_LOCAL: begin
        rx_d_n = host_byte;
        if (host_data_wr) begin
          if (rx_room) rx_n  = 1'b1;
          else         ovr_n = 1'b1;
        end
      end
      default: begin
        tx_n = line_fire && tx_ok;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_push <= 1'b0;
      tx_push <= 1'b0;
      ovr     <= 1'b0;
      rx_data <= '0;
      tx_data <= '0;
    end else begin
      rx_push <= rx_n;
      tx_push <= tx_n;
      ovr     <= ovr_n;
      if (rx_n) rx_data <= rx_d_n;
      if (tx_n) tx_data <= tx_d_n;
    end
  end

  // R3: an echoed line byte always reaches the receive side on the next cycle
  a_r3_echo_pair: assert property (@(posedge clk) disable iff (rst)
    (line_fire && mode == CH_ECHO) |=> rx_push);

  // R6: host data in echo or remote loopback produces no push
  a_r6_host_ignored: assert property (@(posedge clk) disable iff (rst)
    (host_data_wr && (mode == CH_ECHO || mode == CH_REMOTE) && !line_fire)
      |=> (!rx_push && !tx_push));

  // R8: a dropped push never coincides with a transmit push
  a_r8_drop_no_tx: assert property (@(posedge clk) disable iff (rst)
    ovr |-> !tx_push);

  // R4: a line byte in local loopback is discarded
  a_r4_local_discard: assert property (@(posedge clk) disable iff (rst)
    (line_fire && !host_data_wr && mode == CH_LOCAL) |=> (!rx_push && !tx_push));
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import ucr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [HW_W-1:0]   host_wdata,
  input  logic              line_valid,
  output logic              line_ready,
  input  logic [BYTE_W-1:0] line_data,
  input  logic [CW-1:0]     rx_level,
  input  logic [CW-1:0]     tx_level,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_push_data,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_push_data,
  output logic              tx_flush,
  output logic [EVT_W-1:0]  evt_set
);
  chan_mode_e mode;
  logic tx_ok, host_data_wr, rx_room, tx_room, ovr, line_fire;

  ucr_ctrl_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .host_wr      (host_wr),
    .host_sel     (host_sel),
    .wr_txrst     (host_wdata[CB_TXRST]),
    .wr_txen      (host_wdata[CB_TXEN]),
    .wr_txdis     (host_wdata[CB_TXDIS]),
    .wr_mode      (host_wdata[MODE_LSB+1:MODE_LSB]),
    .mode         (mode),
    .tx_ok        (tx_ok),
    .tx_flush     (tx_flush),
    .host_data_wr (host_data_wr)
  );

  ucr_space #(.DEPTH(DEPTH)) u_space (
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_pend    (rx_push),
    .tx_pend    (tx_push),
    .flush_pend (tx_flush),
    .mode       (mode),
    .rx_room    (rx_room),
    .tx_room    (tx_room),
    .line_ready (line_ready)
  );

  assign line_fire = line_valid && line_ready;

  ucr_steer u_steer (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .tx_ok        (tx_ok),
    .host_data_wr (host_data_wr),
    .host_byte    (host_wdata[BYTE_W-1:0]),
    .line_fire    (line_fire),
    .line_byte    (line_data),
    .rx_room      (rx_room),
    .tx_room      (tx_room),
    .rx_push      (rx_push),
    .rx_data      (rx_push_data),
    .tx_push      (tx_push),
    .tx_data      (tx_push_data),
    .ovr          (ovr)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EVT_RXOVR] = ovr;
  end

  // R7: transmit pushes only follow a cycle with transmit enabled
  a_r7_tx_gated: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> $past(tx_ok));

  // R9: a receive push never lands on a full receive FIFO
  a_r9_rx_space: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (rx_level < CW'(DEPTH)));

  // R9: a transmit push never lands on a full transmit FIFO unless it is being emptied
  a_r9_tx_space: assert property (@(posedge clk) disable iff (rst)
    (tx_push && !tx_flush) |-> (tx_level < CW'(DEPTH)));
endmodule

// File: tb/test_uart_chan_router.sv
module test_uart_chan_router;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0;
  logic [1:0] host_sel = 2'd3;
  logic [9:0] host_wdata = '0;
  logic line_valid = 1'b0;
  logic [7:0] line_data = '0;
  logic [CW-1:0] rx_lvl = '0, tx_lvl = '0;
  logic line_ready, rx_push, tx_push, tx_flush;
  logic [7:0] rx_push_data, tx_push_data;
  logic [12:0] evt_set;

  int n_checks = 0, n_fail = 0, evt_cnt = 0, flush_cnt = 0;
  logic [8:0] exp_q[$];
  logic done = 1'b0;

  always #10 clk = ~clk;

  uart_chan_router #(.DEPTH(D)) i_uart_chan_router (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .line_valid(line_valid), .line_ready(line_ready),
    .line_data(line_data), .rx_level(rx_lvl), .tx_level(tx_lvl),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .tx_push(tx_push),
    .tx_push_data(tx_push_data), .tx_flush(tx_flush), .evt_set(evt_set)
  );

  // FIFO level model for the external FIFOs
  always @(posedge clk) begin
    if (rst) begin
      rx_lvl <= '0;
      tx_lvl <= '0;
    end else begin
      if (rx_push) rx_lvl <= rx_lvl + 1'b1;
      if (tx_flush) tx_lvl <= CW'(tx_push);
      else if (tx_push) tx_lvl <= tx_lvl + 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare pushes against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rx_push) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rx push", {1'b0, rx_push_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(e == {1'b0, rx_push_data}, "R2 rx push", {1'b0, rx_push_data}, e);
        end
      end
      if (tx_push) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected tx push", {1'b1, tx_push_data}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(e == {1'b1, tx_push_data}, "R5 tx push", {1'b1, tx_push_data}, e);
        end
      end
      if (evt_set[5]) evt_cnt++;
      if (evt_set != 13'd0 && evt_set != 13'h020)
        chk(1'b0, "R8 event bits", evt_set, 13'h020);
      if (tx_flush) flush_cnt++;
    end
  end

  task automatic host_write(input logic [1:0] s, input logic [9:0] d);
    @(posedge clk); #2;
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk); #2;
    host_wr = 1'b0; host_sel = 2'd3;
  endtask

  task automatic line_send(input logic [7:0] b, input logic exp_rdy, input string tag);
    @(posedge clk); #2;
    line_valid = 1'b1; line_data = b;
    #1 chk(line_ready == exp_rdy, tag, line_ready, exp_rdy);
    @(posedge clk); #2;
    line_valid = 1'b0;
  endtask

  task automatic ctrl(input logic [9:0] v);  host_write(2'd0, v); endtask
  task automatic mode(input logic [9:0] v);  host_write(2'd1, v); endtask
  task automatic hdata(input logic [7:0] b); host_write(2'd2, {2'b00, b}); endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #1;
    // R11: reset state
    chk(!rx_push && !tx_push && !tx_flush, "R11 reset pushes", {rx_push, tx_push, tx_flush}, 0);
    chk(evt_set == 0, "R11 reset events", evt_set, 0);
    chk(line_ready == 1'b1, "R9 ready after reset", line_ready, 1);

    hdata(8'hA1);                      // R7: tx disabled after reset, dropped
    ctrl(10'h010);
    exp_q.push_back({1'b1, 8'hA2}); hdata(8'hA2);          // R2 normal host
    exp_q.push_back({1'b0, 8'hB1}); line_send(8'hB1, 1'b1, "R9 normal ready");  // R2 line
    ctrl(10'h030); hdata(8'hA3);       // R7 disable wins, dropped
    ctrl(10'h010);

    mode(10'h100);                     // echo
    exp_q.push_back({1'b0, 8'hC1}); exp_q.push_back({1'b1, 8'hC1});
    line_send(8'hC1, 1'b1, "R3 echo ready");
    hdata(8'hA4);                      // R6 ignored

    mode(10'h200);                     // local loopback
    exp_q.push_back({1'b0, 8'hD1}); hdata(8'hD1);          // R4
    line_send(8'hE1, 1'b1, "R4 local ready");              // discarded

    mode(10'h300);                     // remote loopback
    exp_q.push_back({1'b1, 8'hF1}); line_send(8'hF1, 1'b1, "R5 remote ready");
    hdata(8'hA5);                      // R6 ignored
    exp_q.push_back({1'b1, 8'h61}); line_send(8'h61, 1'b1, "R5 remote ready 2");
    line_send(8'h55, 1'b0, "R9 remote tx full");
    mode(10'h100);
    line_send(8'h56, 1'b0, "R9 echo tx full");

    mode(10'h000);
    hdata(8'h71);                      // R8 tx full, drop + event
    exp_q.push_back({1'b0, 8'h57}); line_send(8'h57, 1'b1, "R9 normal rx room");
    mode(10'h200);
    hdata(8'h72);                      // R8 rx full, drop + event
    line_send(8'h58, 1'b1, "R9 local always ready");
    mode(10'h000);
    line_send(8'h59, 1'b0, "R9 normal rx full");

    ctrl(10'h012);                     // R10 transmit reset
    mode(10'h300);
    exp_q.push_back({1'b1, 8'h5A}); line_send(8'h5A, 1'b1, "R10 tx empty after flush");
    mode(10'h000);
    exp_q.push_back({1'b1, 8'hB2}); hdata(8'hB2);          // R10 enable kept

    mode(10'h2FF);                     // R1 low bits ignored -> local loopback
    hdata(8'hC2);                      // rx full -> event
    line_send(8'h5B, 1'b1, "R1 mode bits 9:8 select local");

    repeat (4) @(posedge clk);
    #5;
    chk(exp_q.size() == 0, "R2 all expected pushes seen", exp_q.size(), 0);
    chk(evt_cnt == 3, "R8 overrun event count", evt_cnt, 3);
    chk(flush_cnt == 1, "R10 single flush pulse", flush_cnt, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule